// File: doc/BRIEF.md
# Seven-Level Level-Shifted PWM Gate Generator

This block drives the seven power switches of a single-phase seven-level inverter. The inverter has an H-bridge with two legs: leg A holds S1 (high) and S2 (low), leg B holds S3 (high) and S4 (low). The bridge is fed from an auxiliary stage that can present one third of the DC bus (switch Q1), two thirds of the bus (switch Q2) or the full bus (switch Qf). The block takes a signed reference sample, which is the modulation index times the sine. It compares the magnitude of the reference with three stacked triangular carriers. It then sets the auxiliary switch and the bridge polarity so that the terminal voltage takes one of the levels −3..+3 thirds of the bus.

All three carriers come from a single up/down counter. The counter runs from 0 up to `half_per` and back down, so one carrier period lasts 2·`half_per` clock cycles. Carrier k (k = 0, 1, 2) is k·`half_per` plus the counter value, and the three carriers stack into three bands. The reference is captured only at the carrier peak. Every change of auxiliary switch, and every change of side in a bridge leg, passes through an all-off gap whose length is set by `dead_cyc`. The zero level is made by shorting the bridge terminals. During a positive half-cycle both low switches carry the zero state, and during a negative half-cycle both high switches carry it. As a result only leg A moves when the output steps between zero and a non-zero level.

Top module: `ml7_gate_gen`

## Requirements
- R1: While `rst_n` is low, or one cycle after a clock edge that sees `en` low, all seven gates are 0, `lvl_code` is 0 and `peak_stb` is 0.
- R2: While enabled, the carrier counter counts up by one per cycle from 0 until the incremented value reaches `half_per`, then counts down by one per cycle to 0. `peak_stb` is high for exactly the one cycle in which the counter holds its peak value, so it repeats every 2·`half_per` cycles.
- R3: `lvl_code` is a 3-bit two's-complement value. One cycle after each counter value, its magnitude equals the number of carriers k·`half_per` + counter (k = 0, 1, 2) that lie strictly below the magnitude of the held reference. Its sign is negative when the held reference is negative.
- R4: The held reference is loaded from `ref_in` only on the clock edge at which the counter reaches its peak, and it is cleared while disabled. Values on `ref_in` between peaks do not change `lvl_code`.
- R5: A held reference of magnitude at most `half_per` gives at most level ±1. A magnitude at most 2·`half_per` gives at most level ±2. Larger magnitudes reach ±3.
- R6: The auxiliary switch follows the magnitude of the level once it has settled: 1 selects Q1, 2 selects Q2, 3 selects Qf, and 0 selects none. At most one of Qf, Q2 and Q1 is ever on.
- R7: Between turning one auxiliary switch off and turning a different one on, all three stay off for at least `dead_cyc`+1 cycles.
- R8: A settled positive level turns on S1 and S4. A settled negative level turns on S2 and S3.
- R9: A settled zero level turns on S2 and S4 when the held reference is non-negative, and S1 and S3 when it is negative.
- R10: S1 and S2 are never on together, and S3 and S4 are never on together. When a leg changes side, both of its switches stay off for at least `dead_cyc`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces every gate off |
| ref_in | input | REF_W | Signed reference sample (modulation index × sine) |
| half_per | input | CNT_W | Carrier half period in clock cycles (peak counter value) |
| dead_cyc | input | DT_W | Dead-time length in cycles |
| gate_s1 | output | 1 | Leg A high switch |
| gate_s2 | output | 1 | Leg A low switch |
| gate_s3 | output | 1 | Leg B high switch |
| gate_s4 | output | 1 | Leg B low switch |
| gate_qf | output | 1 | Full-bus auxiliary switch |
| gate_q2 | output | 1 | Two-thirds-bus auxiliary switch |
| gate_q1 | output | 1 | One-third-bus auxiliary switch |
| lvl_code | output | 3 | Signed output level, −3..+3 |
| peak_stb | output | 1 | One-cycle strobe at each carrier peak |

## Verification
Every value of an 8-bit reference is held long enough to be captured. This checks, at every cycle, the band count against carrier positions on both slopes, the three-, five- and seven-level magnitude ranges, and the sign handling down to the most negative code. A second pattern changes `ref_in` on every cycle. This separates peak-only capture from continuous sampling, because any design that samples continuously gives levels that differ from the model. Runs with a one-cycle half period and zero dead time, and with a long half period and long dead time, exercise the peak-turnaround corner and the gap counting. They also cover the near-zero negative references that reveal whether the zero state picks its bridge pair by the sign of the reference.

// File: rtl/ml7_pkg.sv
`timescale 1ns/1ps
package ml7_pkg;

    // number of stacked carriers
    localparam int NUM_CAR = 3;

    // dead-time channels: one auxiliary selector, two bridge legs
    localparam int NUM_CH  = 3;
    localparam int CH_AUX  = 0;
    localparam int CH_LEGA = 1;
    localparam int CH_LEGB = 2;

    // auxiliary selector codes (equal to the level magnitude)
    localparam logic [1:0] AUX_NONE  = 2'd0;
    localparam logic [1:0] AUX_THIRD = 2'd1;
    localparam logic [1:0] AUX_TWO   = 2'd2;
    localparam logic [1:0] AUX_FULL  = 2'd3;

    // bridge leg side codes
    localparam logic [1:0] LEG_OFF  = 2'd0;
    localparam logic [1:0] LEG_LOW  = 2'd1;
    localparam logic [1:0] LEG_HIGH = 2'd2;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

endpackage

// File: rtl/ml7_carrier.sv
`timescale 1ns/1ps
// Up/down triangle counter shared by the three stacked carriers.
module ml7_carrier
    import ml7_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] half_per,
    output logic [CNT_W-1:0] cnt_o,
    output logic             peak_next_o,
    output logic             stb_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        dir_e             dir;
        logic             stb;
    } car_st_t;

    car_st_t st_d, st_q;
    logic [CNT_W:0] cnt_inc;
    logic           peak_w;

    always_comb begin
        cnt_inc = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        peak_w  = en && (st_q.dir == DIR_UP) && (cnt_inc >= {1'b0, half_per});

        st_d     = st_q;
        st_d.stb = 1'b0;
        if (!en) begin
            st_d.cnt = '0;
            st_d.dir = DIR_UP;
        end else if (st_q.dir == DIR_UP) begin
            st_d.cnt = cnt_inc[CNT_W-1:0];
            if (peak_w) begin
                st_d.dir = DIR_DOWN;
                st_d.stb = 1'b1;
            end
        end else begin
            st_d.cnt = (st_q.cnt == '0) ? '0 : st_q.cnt - 1'b1;
            if (st_q.cnt <= {{(CNT_W-1){1'b0}}, 1'b1}) begin
                st_d.dir = DIR_UP;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.dir <= DIR_UP;
            st_q.stb <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o       = st_q.cnt;
    assign peak_next_o = peak_w;
    assign stb_o       = st_q.stb;

endmodule

// File: rtl/ml7_band.sv
`timescale 1ns/1ps
// Compares the rectified held reference with the stacked carriers and
// registers the signed level.
module ml7_band
    import ml7_pkg::*;
#(
    parameter int REF_W = 16,
    parameter int CNT_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [REF_W-1:0] hold,
    input  logic [CNT_W-1:0]        cnt,
    input  logic [CNT_W-1:0]        half_per,
    output logic signed [2:0]       lvl_o,
    output logic                    neg_o
);

    localparam int WIDE  = (REF_W > CNT_W + 2) ? REF_W : CNT_W + 2;
    localparam int CMP_W = WIDE + 1;

    typedef struct packed {
        logic signed [2:0] lvl;
        logic              neg;
    } band_st_t;

    band_st_t          st_d, st_q;
    logic [CMP_W-1:0]  mag;
    logic [CMP_W-1:0]  hext;
    logic [CMP_W-1:0]  pext;
    logic [CMP_W-1:0]  cext;
    logic [CMP_W-1:0]  car [NUM_CAR];
    logic [1:0]        band;
    logic              hneg;

    always_comb begin
        hneg = hold[REF_W-1];
        hext = CMP_W'(hold);
        mag  = hneg ? (~hext + 1'b1) : hext;
        pext = CMP_W'(half_per);
        cext = CMP_W'(cnt);
        band = 2'd0;
        for (int k = 0; k < NUM_CAR; k++) begin
            car[k] = pext * CMP_W'(k) + cext;
            if (mag > car[k]) begin
                band = band + 2'd1;
            end
        end

        st_d = st_q;
        if (!en) begin
            st_d.lvl = '0;
            st_d.neg = 1'b0;
        end else begin
            st_d.neg = hneg;
            st_d.lvl = hneg ? -$signed({1'b0, band}) : $signed({1'b0, band});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;
    assign neg_o = st_q.neg;

endmodule

// File: rtl/ml7_deadtime.sv
`timescale 1ns/1ps
// One selector channel: switches between codes only through an all-off
// gap of dead+1 cycles. Code 0 means every switch of the channel is off.
module ml7_deadtime #(
    parameter int DT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      want,
    input  logic [DT_W-1:0] dead,
    output logic [1:0]      cur_o
);

    typedef struct packed {
        logic [1:0]      cur;
        logic [DT_W-1:0] cnt;
    } dt_st_t;

    dt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (want != st_q.cur) begin
            if (st_q.cur != 2'd0) begin
                st_d.cur = 2'd0;
                st_d.cnt = dead;
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end else begin
                st_d.cur = want;
            end
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o = st_q.cur;

endmodule

// File: rtl/ml7_gate_gen.sv
`timescale 1ns/1ps
module ml7_gate_gen
    import ml7_pkg::*;
#(
    parameter int REF_W = 16,
    parameter int CNT_W = 14,
    parameter int DT_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic [CNT_W-1:0]        half_per,
    input  logic [DT_W-1:0]         dead_cyc,
    output logic                    gate_s1,
    output logic                    gate_s2,
    output logic                    gate_s3,
    output logic                    gate_s4,
    output logic                    gate_qf,
    output logic                    gate_q2,
    output logic                    gate_q1,
    output logic signed [2:0]       lvl_code,
    output logic                    peak_stb
);

    typedef struct packed {
        logic signed [REF_W-1:0] hold;
    } top_st_t;

    top_st_t                 st_d, st_q;
    logic [CNT_W-1:0]        cnt;
    logic                    peak_next;
    logic signed [2:0]       lvl;
    logic                    neg;
    logic [1:0]              mag;
    logic                    zero_lvl;
    logic                    leg_a_high;
    logic [1:0]              want [NUM_CH];
    logic [1:0]              cur  [NUM_CH];

    ml7_carrier #(.CNT_W(CNT_W)) carrier_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .half_per    (half_per),
        .cnt_o       (cnt),
        .peak_next_o (peak_next),
        .stb_o       (peak_stb)
    );

    // reference capture at the carrier peak only
    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.hold = '0;
        end else if (peak_next) begin
            st_d.hold = ref_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    ml7_band #(.REF_W(REF_W), .CNT_W(CNT_W)) band_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .hold     (st_q.hold),
        .cnt      (cnt),
        .half_per (half_per),
        .lvl_o    (lvl),
        .neg_o    (neg)
    );

    // steering: level magnitude picks the auxiliary switch, sign picks the
    // bridge diagonal, zero shorts the terminals through the same-side pair
    always_comb begin
        mag        = lvl[2] ? 2'(-lvl) : lvl[1:0];
        zero_lvl   = (lvl == 3'sd0);
        leg_a_high = (!neg) ^ zero_lvl;
        if (en) begin
            want[CH_AUX]  = mag;
            want[CH_LEGA] = leg_a_high ? LEG_HIGH : LEG_LOW;
            want[CH_LEGB] = neg ? LEG_HIGH : LEG_LOW;
        end else begin
            want[CH_AUX]  = AUX_NONE;
            want[CH_LEGA] = LEG_OFF;
            want[CH_LEGB] = LEG_OFF;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dt
        ml7_deadtime #(.DT_W(DT_W)) dt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (want[g]),
            .dead  (dead_cyc),
            .cur_o (cur[g])
        );
    end

    assign gate_q1  = (cur[CH_AUX]  == AUX_THIRD);
    assign gate_q2  = (cur[CH_AUX]  == AUX_TWO);
    assign gate_qf  = (cur[CH_AUX]  == AUX_FULL);
    assign gate_s1  = (cur[CH_LEGA] == LEG_HIGH);
    assign gate_s2  = (cur[CH_LEGA] == LEG_LOW);
    assign gate_s3  = (cur[CH_LEGB] == LEG_HIGH);
    assign gate_s4  = (cur[CH_LEGB] == LEG_LOW);
    assign lvl_code = lvl;

endmodule

// File: rtl/ml7_gate_chk.sv
`timescale 1ns/1ps
module ml7_gate_chk #(
    parameter int DT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [DT_W-1:0]   dead_cyc,
    input logic              gate_s1,
    input logic              gate_s2,
    input logic              gate_s3,
    input logic              gate_s4,
    input logic              gate_qf,
    input logic              gate_q2,
    input logic              gate_q1,
    input logic signed [2:0] lvl_code,
    input logic              peak_stb
);

    logic [2:0]    aux_on;
    logic [2:0]    last_q;
    logic [DT_W:0] gap_q;

    assign aux_on = {gate_qf, gate_q2, gate_q1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
            gap_q  <= '0;
        end else if (aux_on == 3'b000) begin
            if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
        end else begin
            gap_q  <= '0;
            last_q <= aux_on;
        end
    end

    // R6
    aux_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(aux_on));

    // R10
    leg_a_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_s1 && gate_s2));

    // R10
    leg_b_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_s3 && gate_s4));

    // R7
    aux_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_on != 3'b000 && last_q != 3'b000 && aux_on != last_q)
        |-> (gap_q > {1'b0, dead_cyc}));

    // R1
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ({gate_s1, gate_s2, gate_s3, gate_s4, aux_on} == 7'd0
                 && lvl_code == 3'sd0));

    // R2
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_stb |=> !peak_stb);

    // R3
    lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_code != -3'sd4);

endmodule

bind ml7_gate_gen ml7_gate_chk #(.DT_W(DT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .dead_cyc (dead_cyc),
    .gate_s1  (gate_s1),
    .gate_s2  (gate_s2),
    .gate_s3  (gate_s3),
    .gate_s4  (gate_s4),
    .gate_qf  (gate_qf),
    .gate_q2  (gate_q2),
    .gate_q1  (gate_q1),
    .lvl_code (lvl_code),
    .peak_stb (peak_stb)
);

// File: tb/ml7_gate_gen_tb_top.sv
`timescale 1ns/1ps
module ml7_gate_gen_tb_top;

    localparam int REF_W = 8;
    localparam int CNT_W = 4;
    localparam int DT_W  = 3;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic                    en;
    logic signed [REF_W-1:0] ref_in;
    logic [CNT_W-1:0]        half_per;
    logic [DT_W-1:0]         dead_cyc;
    logic gate_s1, gate_s2, gate_s3, gate_s4, gate_qf, gate_q2, gate_q1;
    logic signed [2:0]       lvl_code;
    logic                    peak_stb;

    always #2.5 clk = ~clk;

    ml7_gate_gen #(.REF_W(REF_W), .CNT_W(CNT_W), .DT_W(DT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .ref_in(ref_in),
        .half_per(half_per), .dead_cyc(dead_cyc),
        .gate_s1(gate_s1), .gate_s2(gate_s2), .gate_s3(gate_s3),
        .gate_s4(gate_s4), .gate_qf(gate_qf), .gate_q2(gate_q2),
        .gate_q1(gate_q1), .lvl_code(lvl_code), .peak_stb(peak_stb)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit chk_on = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // arithmetic model of carrier, capture and level, advanced on each edge
    int m_c = 0, m_hold = 0, m_lvl = 0, m_run = 0;
    bit m_up = 1'b1, m_stb = 1'b0, m_neg = 1'b0, m_en = 1'b0;

    always @(posedge clk) begin
        int p_lvl, a, p, band;
        bit p_neg, p_en;
        p_lvl = m_lvl; p_neg = m_neg; p_en = m_en;
        if (!rst_n || !en) begin
            m_c = 0; m_up = 1'b1; m_stb = 1'b0; m_hold = 0;
            m_lvl = 0; m_neg = 1'b0; m_en = 1'b0;
        end else begin
            p = int'(half_per);
            a = (m_hold < 0) ? -m_hold : m_hold;
            band = 0;
            for (int k = 0; k < 3; k++) if (a > k * p + m_c) band++;
            m_lvl = (m_hold < 0) ? -band : band;
            m_neg = (m_hold < 0);
            m_en  = 1'b1;
            if (m_up) begin
                m_c++;
                m_stb = (m_c >= p);
                if (m_stb) begin
                    m_up = 1'b0;
                    m_hold = int'(ref_in);
                end
            end else begin
                m_stb = 1'b0;
                if (m_c <= 1) m_up = 1'b1;
                m_c = (m_c == 0) ? 0 : m_c - 1;
            end
        end
        if (p_lvl == m_lvl && p_neg == m_neg && p_en == m_en) m_run++;
        else m_run = 1;
    end

    // per-cycle monitor
    int g_last [3] = '{0, 0, 0};
    int g_gap  [3] = '{0, 0, 0};

    always @(negedge clk) begin
        int code [3];
        int e_aux, e_a, e_b, d;
        if (chk_on) begin
            d = int'(dead_cyc);
            chk(lvl_code == m_lvl, "R3 level", int'(lvl_code), m_lvl);
            chk(peak_stb == m_stb, "R2 strobe", int'(peak_stb), int'(m_stb));
            code[0] = gate_qf ? 3 : gate_q2 ? 2 : gate_q1 ? 1 : 0;
            code[1] = gate_s1 ? 2 : gate_s2 ? 1 : 0;
            code[2] = gate_s3 ? 2 : gate_s4 ? 1 : 0;
            chk($countones({gate_qf, gate_q2, gate_q1}) <= 1, "R6 aux exclusive",
                $countones({gate_qf, gate_q2, gate_q1}), 1);
            chk(!(gate_s1 && gate_s2) && !(gate_s3 && gate_s4), "R10 leg exclusive",
                int'({gate_s1, gate_s2, gate_s3, gate_s4}), 0);
            if (!m_en || m_run >= d + 3) begin
                if (!m_en) begin
                    e_aux = 0; e_a = 0; e_b = 0;
                end else begin
                    e_aux = (m_lvl < 0) ? -m_lvl : m_lvl;
                    e_a   = ((!m_neg) ^ (m_lvl == 0)) ? 2 : 1;
                    e_b   = m_neg ? 2 : 1;
                end
                chk(code[0] == e_aux, m_en ? "R6 aux select" : "R1 aux off", code[0], e_aux);
                chk(code[1] == e_a && code[2] == e_b,
                    !m_en ? "R1 legs off" : (m_lvl == 0) ? "R9 zero pair" : "R8 polarity",
                    code[1] * 4 + code[2], e_a * 4 + e_b);
            end
            for (int k = 0; k < 3; k++) begin
                if (code[k] == 0) begin
                    g_gap[k]++;
                end else begin
                    if (g_last[k] != 0 && code[k] != g_last[k])
                        chk(g_gap[k] >= d + 1, (k == 0) ? "R7 aux gap" : "R10 leg gap",
                            g_gap[k], d + 1);
                    g_gap[k]  = 0;
                    g_last[k] = code[k];
                end
            end
        end
    end

    task automatic sweep(input int lo, input int hi, input int cyc, input bool_r5);
        for (int v = lo; v <= hi; v++) begin
            ref_in = 8'(v);
            for (int i = 0; i < cyc; i++) begin
                @(negedge clk);
                if (bool_r5 != 0 && i >= 2 * int'(half_per) + 3) begin
                    int a, l;
                    a = (v < 0) ? -v : v;
                    l = (lvl_code < 0) ? -int'(lvl_code) : int'(lvl_code);
                    if (a <= int'(half_per))
                        chk(l <= 1, "R5 three-level range", l, 1);
                    else if (a <= 2 * int'(half_per))
                        chk(l <= 2, "R5 five-level range", l, 2);
                end
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0; ref_in = '0; half_per = 4'd4; dead_cyc = 3'd2;
        repeat (3) @(negedge clk);
        chk({gate_s1, gate_s2, gate_s3, gate_s4, gate_qf, gate_q2, gate_q1} == 7'd0,
            "R1 reset gates", int'({gate_s1, gate_s2, gate_s3, gate_s4, gate_qf, gate_q2, gate_q1}), 0);
        chk(lvl_code == 3'sd0 && !peak_stb, "R1 reset level", int'(lvl_code), 0);
        rst_n = 1'b1;
        chk_on = 1'b1;
        repeat (2) @(negedge clk);
        en = 1'b1;

        // every reference code, each held for two carrier periods
        sweep(-128, 127, 16, 1);

        // R4: reference changes every cycle; only peak samples count
        for (int i = 0; i < 512; i++) begin
            ref_in = 8'((i * 37 + 11) % 256);
            @(negedge clk);
        end

        // R1: disable mid-run
        ref_in = 8'sd100;
        repeat (20) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk({gate_s1, gate_s2, gate_s3, gate_s4, gate_qf, gate_q2, gate_q1} == 7'd0,
            "R1 disable gates", int'({gate_s1, gate_s2, gate_s3, gate_s4, gate_qf, gate_q2, gate_q1}), 0);
        chk(lvl_code == 3'sd0, "R1 disable level", int'(lvl_code), 0);
        repeat (20) @(negedge clk);

        // shortest carrier, no dead time
        half_per = 4'd1; dead_cyc = 3'd0;
        en = 1'b1;
        sweep(-6, 6, 12, 1);
        en = 1'b0;
        repeat (20) @(negedge clk);

        // long carrier, long dead time
        half_per = 4'd6; dead_cyc = 3'd5;
        en = 1'b1;
        sweep(-20, 20, 40, 1);

        chk_on = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule